// File: doc/BRIEF.md
# Idle-Driven Core Power Manager

This block decides which cores of a small multi-core cluster are powered. It watches one busy flag per core and a single flag saying that a task is waiting at the head of the shared task queue. A free-running scan timer fires once every `idleLimit` cycles. At each firing, every powered, ready core that has been idle for at least `idleLimit` consecutive cycles is switched off. One core always stays powered.

When a task is waiting and no powered core is free, the manager powers up the lowest-numbered switched-off core. That core is reported as ready only after a programmable on-latency. Only one wake-up is in flight at any time.

The outputs drive the power switches of the cores and tell a dispatcher which cores can accept work.

Top module: `core_power_manager`

## Requirements
- R1: Throughout reset and on leaving it, every bit of `corePowered` and every bit of `coreReady` is 1.
- R2: A core's idle count is the number of consecutive cycles in which it has been powered, ready and not busy. A core is switched off only at a scan tick, and only if its idle count has reached `idleLimit`. Scan ticks fall every `idleLimit` cycles, counted from reset. With everything idle after reset, no core goes off within the first 1.5×`idleLimit` cycles. By 2.5×`idleLimit` cycles, all cores but one are off.
- R3: A core whose `coreBusy` bit is 1 is never switched off in the following cycle.
- R4: `corePowered` is never all zero. If every powered core qualifies for switch-off at the same tick, the lowest-index one stays on. If at least one powered core does not qualify, every qualifying core goes off.
- R5: Suppose `taskWaiting` is 1, no core is free, at least one core is off and no wake is in flight. Then the lowest-index off core has its `corePowered` bit set at the next clock edge. A free core is one that is powered, ready and not busy.
- R6: No core is powered up if `taskWaiting` is 0, if a free core exists, or if no core is off.
- R7: A woken core's `coreReady` bit rises exactly `onLatency`+1 clock edges after its `corePowered` bit rises, and stays 0 before that.
- R8: At most one `corePowered` bit rises per cycle. No new wake starts before the previous woken core is ready.
- R9: A `coreReady` bit is 1 only while the matching `corePowered` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idleLimit | input | CNT_W | Scan period and idle-duration limit in cycles, at least 1 |
| onLatency | input | LAT_W | Cycles from power-up until a woken core is usable |
| coreBusy | input | NUM_CORES | One bit per core, 1 while the core runs a task |
| taskWaiting | input | 1 | A task sits at the head of the shared queue |
| corePowered | output | NUM_CORES | One bit per core, 1 while its power switch is closed |
| coreReady | output | NUM_CORES | One bit per core, 1 when the core is powered and usable |

## Verification
The checks on power-off and wake ordering assume that the dispatcher never marks a core busy unless that core is powered and ready. The bench raises `coreBusy` bits only for cores the design currently reports ready. The checks also assume that `idleLimit` and `onLatency` stay constant while a scan period or a wake is in progress. The bench changes `onLatency` only when no wake is in flight, and it never changes `idleLimit` after reset.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic wakeStart;   // load the on-latency counter
    logic wakeActive;  // a woken core is still waiting for its latency
  } ctrlStrobes_t;
endpackage

// File: rtl/cpm_datapath.sv
module cpm_datapath
  import cpm_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 16,
  parameter int LAT_W     = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     idleLimit,
  input  logic [LAT_W-1:0]     onLatency,
  input  logic [NUM_CORES-1:0] coreBusy,
  input  logic [NUM_CORES-1:0] corePowered,
  input  logic [NUM_CORES-1:0] coreReady,
  input  ctrlStrobes_t         strobes,
  output logic                 scanTick,
  output logic [NUM_CORES-1:0] overLimit,
  output logic                 latDone
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(1);

  logic [CNT_W-1:0] scanCnt;
  logic [LAT_W-1:0] latCnt;

  // Periodic scan timer: one tick every idleLimit cycles
  assign scanTick = (scanCnt >= idleLimit - CNT_ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)        scanCnt <= '0;
    else if (scanTick) scanCnt <= '0;
    else               scanCnt <= scanCnt + CNT_ONE;
  end

  // Per-core saturating idle-duration counters
  for (genvar i = 0; i < NUM_CORES; i++) begin : g_idle
    logic [CNT_W-1:0] idleCnt;
    always_ff @(posedge clk) begin
      if (!rst_n)
        idleCnt <= '0;
      else if (!corePowered[i] || !coreReady[i] || coreBusy[i])
        idleCnt <= '0;
      else if (idleCnt != CNT_MAX)
        idleCnt <= idleCnt + CNT_ONE;
    end
    assign overLimit[i] = (idleCnt >= idleLimit);
  end

  // On-latency down-counter for the single wake in flight
  always_ff @(posedge clk) begin
    if (!rst_n)                                   latCnt <= '0;
    else if (strobes.wakeStart)                   latCnt <= onLatency;
    else if (strobes.wakeActive && latCnt != '0)  latCnt <= latCnt - LAT_ONE;
  end

  assign latDone = (latCnt == '0);
endmodule

// File: rtl/cpm_control.sv
module cpm_control
  import cpm_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] coreBusy,
  input  logic                 taskWaiting,
  input  logic                 scanTick,
  input  logic [NUM_CORES-1:0] overLimit,
  input  logic                 latDone,
  output ctrlStrobes_t         strobes,
  output logic [NUM_CORES-1:0] corePowered,
  output logic [NUM_CORES-1:0] coreReady
);
  localparam logic [NUM_CORES-1:0] VEC_ONE = NUM_CORES'(1);

  logic [NUM_CORES-1:0] freeVec, candVec, keepVec, offMask;
  logic [NUM_CORES-1:0] offVec, wakeHot, pendHot;
  logic                 inFlight, needWake, finishWake;

  assign freeVec = corePowered & coreReady & ~coreBusy;
  assign candVec = freeVec & overLimit & {NUM_CORES{scanTick}};

  // Keep the lowest-index candidate if every powered core would go off
  assign keepVec = (candVec == corePowered) ? (candVec & (~candVec + VEC_ONE)) : '0;
  assign offMask = candVec & ~keepVec;

  // Wake the lowest-index switched-off core
  assign offVec   = ~corePowered;
  assign wakeHot  = offVec & (~offVec + VEC_ONE);
  assign needWake = taskWaiting && (freeVec == '0) && (offVec != '0) && !inFlight;

  assign finishWake = inFlight && latDone;

  assign strobes.wakeStart  = needWake;
  assign strobes.wakeActive = inFlight;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      corePowered <= '1;
      coreReady   <= '1;
      inFlight    <= 1'b0;
      pendHot     <= '0;
    end else begin
      corePowered <= (corePowered & ~offMask) | (needWake ? wakeHot : '0);
      coreReady   <= (coreReady & ~offMask) | (finishWake ? pendHot : '0);
      if (needWake) begin
        inFlight <= 1'b1;
        pendHot  <= wakeHot;
      end else if (finishWake) begin
        inFlight <= 1'b0;
        pendHot  <= '0;
      end
    end
  end
endmodule

// File: rtl/core_power_manager.sv
module core_power_manager
  import cpm_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 16,
  parameter int LAT_W     = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     idleLimit,
  input  logic [LAT_W-1:0]     onLatency,
  input  logic [NUM_CORES-1:0] coreBusy,
  input  logic                 taskWaiting,
  output logic [NUM_CORES-1:0] corePowered,
  output logic [NUM_CORES-1:0] coreReady
);
  ctrlStrobes_t         strobes;
  logic                 scanTick, latDone;
  logic [NUM_CORES-1:0] overLimit;

  cpm_datapath #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W), .LAT_W(LAT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .idleLimit(idleLimit), .onLatency(onLatency),
    .coreBusy(coreBusy), .corePowered(corePowered), .coreReady(coreReady),
    .strobes(strobes), .scanTick(scanTick), .overLimit(overLimit), .latDone(latDone)
  );

  cpm_control #(.NUM_CORES(NUM_CORES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .coreBusy(coreBusy), .taskWaiting(taskWaiting),
    .scanTick(scanTick), .overLimit(overLimit), .latDone(latDone),
    .strobes(strobes), .corePowered(corePowered), .coreReady(coreReady)
  );
endmodule

// File: rtl/cpm_checker.sv
module cpm_checker #(
  parameter int NUM_CORES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CORES-1:0] coreBusy,
  input logic                 taskWaiting,
  input logic [NUM_CORES-1:0] corePowered,
  input logic [NUM_CORES-1:0] coreReady
);
  // R4: some core is always powered
  p_keep_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    corePowered != '0);

  // R3: a busy powered core is still powered one cycle later
  p_busy_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(corePowered) & $past(coreBusy) & ~corePowered) == '0));

  // R8: no more than one power-up per cycle
  p_one_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(corePowered & ~$past(corePowered)) <= 1));

  // R6: power-up only follows a waiting task
  p_wake_task_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((corePowered & ~$past(corePowered)) != '0) |-> $past(taskWaiting));

  // R9: ready implies powered
  p_ready_pow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (coreReady & ~corePowered) == '0);

  // R7: a ready bit never rises on the same edge as its power bit
  p_ready_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((coreReady & ~$past(coreReady) & ~$past(corePowered)) == '0));
endmodule

bind core_power_manager cpm_checker #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk(clk), .rst_n(rst_n), .coreBusy(coreBusy), .taskWaiting(taskWaiting),
  .corePowered(corePowered), .coreReady(coreReady)
);

// File: tb/core_power_manager_test.sv
`timescale 1ns/100ps
module core_power_manager_test;
  localparam int N  = 4;
  localparam int CW = 16;
  localparam int LW = 12;
  localparam int LIM = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] idleLimit = CW'(LIM);
  logic [LW-1:0] onLatency = LW'(3);
  logic [N-1:0]  coreBusy = '0;
  logic          taskWaiting = 1'b0;
  logic [N-1:0]  corePowered, coreReady;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  core_power_manager #(.NUM_CORES(N), .CNT_W(CW), .LAT_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .idleLimit(idleLimit), .onLatency(onLatency),
    .coreBusy(coreBusy), .taskWaiting(taskWaiting),
    .corePowered(corePowered), .coreReady(coreReady)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tReset;
    rst_n = 1'b0; coreBusy = '0; taskWaiting = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    chk("R1 powered", corePowered, 4'b1111);
    chk("R1 ready", coreReady, 4'b1111);
  endtask

  task automatic tIdleOff;
    cyc(12);
    chk("R2 none off before limit", corePowered, 4'b1111);
    cyc(8);
    chk("R2/R4 idle off, lowest kept", corePowered, 4'b0001);
    chk("R9 ready follows power", coreReady, 4'b0001);
  endtask

  task automatic tWake;
    coreBusy = 4'b0001; taskWaiting = 1'b1;
    cyc(1);
    chk("R5 lowest off core woken", corePowered, 4'b0011);
    chk("R7 not ready at power-up", coreReady, 4'b0001);
    cyc(3);
    chk("R7 not ready before latency", coreReady, 4'b0001);
    chk("R8 no second wake in flight", corePowered, 4'b0011);
    cyc(1);
    chk("R7 ready after latency+1", coreReady, 4'b0011);
    cyc(1);
    chk("R6 no wake with free core", corePowered, 4'b0011);
    coreBusy = 4'b0011;
    cyc(1);
    chk("R5 next lowest woken", corePowered, 4'b0111);
    cyc(5);
    chk("R7 second core ready", coreReady, 4'b0111);
  endtask

  task automatic tNoTask;
    coreBusy = 4'b0111; taskWaiting = 1'b0;
    cyc(4);
    chk("R6 no wake without task", corePowered, 4'b0111);
  endtask

  task automatic tZeroLat;
    onLatency = '0; taskWaiting = 1'b1;
    cyc(1);
    chk("R5 last core woken", corePowered, 4'b1111);
    chk("R7 zero latency not yet ready", coreReady, 4'b0111);
    cyc(1);
    chk("R7 zero latency ready next edge", coreReady, 4'b1111);
    coreBusy = 4'b1111;
    cyc(3);
    chk("R6 none off, nothing changes", corePowered, 4'b1111);
    chk("R3 busy cores stay ready", coreReady, 4'b1111);
  endtask

  task automatic tBusyKept;
    taskWaiting = 1'b0; coreBusy = 4'b0100;
    cyc(3 * LIM + 4);
    chk("R3/R4 busy kept, all idle off", corePowered, 4'b0100);
    coreBusy = 4'b0000;
    cyc(4 * LIM);
    chk("R4 sole core never off", corePowered, 4'b0100);
    chk("R9 ready of sole core", coreReady, 4'b0100);
  endtask

  initial begin
    fork
      begin
        tReset();
        tIdleOff();
        tWake();
        tNoTask();
        tZeroLat();
        tBusyKept();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule